// File: doc/BRIEF.md
# Dual-Clock Packet Buffer with FIFO and Memory-Mapped Faces

This block holds packet bytes for both directions between a network port and a local controller, each in its own dual-port RAM. The network side runs on its own clock. It sees a plain stream: it pushes received bytes with an end-of-frame mark, and it pops transmit bytes whenever they are available. The controller side runs on an unrelated clock and sees both RAMs as circular buffers it addresses directly. It also has a four-entry pointer window. Through this window it learns where the latest received frame ends, releases receive space, commits transmit bytes and watches the transmit backlog.

Every pointer that crosses between the clocks travels in Gray code through a two-flop synchronizer. The controller writes a target value for its pointers. The pointer that is actually published to the network side walks toward that target one step per controller cycle, so each crossing value changes by only one bit at a time. The receive frame-end pointer is captured on the network side at the last byte of a frame. It is held there and handed over with a toggle, and the controller gets a one-cycle pulse when it lands.

Top module: `xdomain_pkt_buf`

## Requirements
- R1: After reset, `rx_full` and `tx_avail` are low, the frame-end register (window index 0) reads 0, and the transmit status register (index 3) reads 0x8000 (empty flag in bit CW-1, level 0 in the low bits).
- R2: Bytes accepted on the network side are stored in arrival order, and the byte with pointer p is read by the controller from the receive RAM at address p mod DEPTH, one controller cycle after the address is presented.
- R3: Accepting a byte with `rx_last` set latches the pointer that follows it (modulo 2^(AW+1)) into window index 0, and `ctl_rx_frame` pulses for one controller cycle in the cycle that value appears.
- R4: `rx_full` is high while DEPTH bytes lie between the network write pointer and the synchronized controller read pointer. A push while full is ignored: nothing is stored, and no frame end or pulse results.
- R5: Writing window index 1 sets the receive read pointer. Once it has crossed, the freed space clears `rx_full`, and later frames are stored after the earlier ones.
- R6: Bytes written by the controller into the transmit RAM appear on `tx_byte`, with `tx_avail` high, in pointer order once window index 2 is written with the advanced write pointer. Each `tx_pop` moves to the next byte.
- R7: `tx_pop` while `tx_avail` is low is ignored, and later transmit bytes are still delivered in order from the first one.
- R8: Window index 3 returns the committed transmit write pointer minus the synchronized network read pointer in its low AW+1 bits, and sets bit CW-1 exactly when that difference is zero.
- R9: All pointers are AW+1 bits wide and wrap modulo 2^(AW+1), so the buffers are reused circularly across many frames.
- R10: Reads of index 1 and index 2 return the written target at once. The committed pointer moves toward the target by at most one per controller cycle, so the transmit level rises gradually after a commit.
- R11: Writes to window indexes 0 and 3, and controller writes with the receive RAM selected, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| net_clk | input | 1 | Network-side clock |
| net_rst_n | input | 1 | Network-side asynchronous reset, active low |
| rx_push | input | 1 | Push one received byte |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | Marks the pushed byte as the end of a frame |
| rx_full | output | 1 | Receive buffer full; pushes are ignored |
| tx_pop | input | 1 | Consume the current transmit byte |
| tx_byte | output | 8 | Current transmit byte (show-ahead) |
| tx_avail | output | 1 | A committed transmit byte is available |
| ctl_clk | input | 1 | Controller clock, asynchronous to net_clk |
| ctl_rst_n | input | 1 | Controller-side asynchronous reset, active low |
| ctl_sel | input | 2 | Access target: 0 none, 1 pointer window, 2 receive RAM, 3 transmit RAM |
| ctl_addr | input | AW | RAM address, or window index in bits 1:0 |
| ctl_we | input | 1 | Write strobe for the selected target |
| ctl_wdata | input | CW | Write data (byte in bits 7:0, pointer in bits AW:0) |
| ctl_rdata | output | CW | Registered read data, valid one cycle after the access |
| ctl_rx_frame | output | 1 | One-cycle pulse when a new frame end is latched |

## Verification
The assertions take for granted that the controller never moves its receive read pointer past the latched frame end. They also assume it never commits more than DEPTH transmit bytes beyond what the network side has consumed, and that successive frame ends are spaced far enough apart for each toggle to be seen on its own. The stimulus respects all three. It waits for each frame pulse before sending the next frame, releases receive space only up to the frame end it has read back, and commits transmit bytes only after the previous batch has been fully popped. Frame lengths and payloads are drawn at random from a fixed seed, and directed cases cover the full buffer, stray pops and writes to read-only targets.

// File: rtl/xdomain_pkt_buf.sv
module xdomain_pkt_buf #(
  parameter int AW = 4,
  parameter int CW = 16
) (
  input  logic          net_clk,
  input  logic          net_rst_n,
  input  logic          rx_push,
  input  logic [7:0]    rx_byte,
  input  logic          rx_last,
  output logic          rx_full,
  input  logic          tx_pop,
  output logic [7:0]    tx_byte,
  output logic          tx_avail,
  input  logic          ctl_clk,
  input  logic          ctl_rst_n,
  input  logic [1:0]    ctl_sel,
  input  logic [AW-1:0] ctl_addr,
  input  logic          ctl_we,
  input  logic [CW-1:0] ctl_wdata,
  output logic [CW-1:0] ctl_rdata,
  output logic          ctl_rx_frame
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [1:0] SEL_WIN = 2'd1, SEL_RX = 2'd2, SEL_TX = 2'd3;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [7:0] rx_mem [DEPTH];
  logic [7:0] tx_mem [DEPTH];

  // network domain
  logic [PW-1:0] rx_wp, rx_fp_g, rx_rd_s1, rx_rd_s2, tx_rd, tx_rd_g, tx_wr_s1, tx_wr_s2;
  logic          rx_tog;
  // controller domain
  logic [PW-1:0] rx_rd_tgt, rx_rd, rx_rd_g, tx_wr_tgt, tx_wr, tx_wr_g, tx_rd_s1, tx_rd_s2, rx_end;
  logic          fp_s1, fp_s2, fp_s3;

  logic [PW-1:0] rx_rd_b, tx_wr_b, tx_rd_b, tx_lvl;
  logic          rx_accept, ctl_win_wr;
  logic [CW-1:0] win_q;

  assign rx_rd_b   = g2b(rx_rd_s2);
  assign tx_wr_b   = g2b(tx_wr_s2);
  assign tx_rd_b   = g2b(tx_rd_s2);
  assign rx_full   = (rx_wp - rx_rd_b) == FULL_LVL;
  assign rx_accept = rx_push && !rx_full;
  assign tx_avail  = tx_rd != tx_wr_b;
  assign tx_byte   = tx_mem[tx_rd[AW-1:0]];
  assign tx_lvl    = tx_wr - tx_rd_b;
  assign ctl_win_wr = ctl_we && ctl_sel == SEL_WIN;

  wire unused_wdata = ^ctl_wdata[CW-1:8];

  always_ff @(posedge net_clk)
    if (rx_accept) rx_mem[rx_wp[AW-1:0]] <= rx_byte;

  always_ff @(posedge net_clk or negedge net_rst_n) begin
    if (!net_rst_n) begin
      rx_wp <= '0; rx_fp_g <= '0; rx_tog <= 1'b0;
      rx_rd_s1 <= '0; rx_rd_s2 <= '0;
      tx_rd <= '0; tx_rd_g <= '0; tx_wr_s1 <= '0; tx_wr_s2 <= '0;
    end else begin
      rx_rd_s1 <= rx_rd_g;  rx_rd_s2 <= rx_rd_s1;
      tx_wr_s1 <= tx_wr_g;  tx_wr_s2 <= tx_wr_s1;
      tx_rd_g  <= b2g(tx_rd);
      if (rx_accept) begin
        rx_wp <= rx_wp + 1'b1;
        if (rx_last) begin
          rx_fp_g <= b2g(rx_wp + 1'b1);
          rx_tog  <= ~rx_tog;
        end
      end
      if (tx_pop && tx_avail) tx_rd <= tx_rd + 1'b1;
    end
  end

  always_ff @(posedge ctl_clk)
    if (ctl_we && ctl_sel == SEL_TX) tx_mem[ctl_addr] <= ctl_wdata[7:0];

  always_comb begin
    win_q = '0;
    case (ctl_addr[1:0])
      2'd0: win_q[PW-1:0] = rx_end;
      2'd1: win_q[PW-1:0] = rx_rd_tgt;
      2'd2: win_q[PW-1:0] = tx_wr_tgt;
      default: begin
        win_q[PW-1:0] = tx_lvl;
        win_q[CW-1]   = tx_lvl == '0;
      end
    endcase
  end

  always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) begin
      rx_rd_tgt <= '0; rx_rd <= '0; rx_rd_g <= '0;
      tx_wr_tgt <= '0; tx_wr <= '0; tx_wr_g <= '0;
      tx_rd_s1 <= '0; tx_rd_s2 <= '0; rx_end <= '0;
      fp_s1 <= 1'b0; fp_s2 <= 1'b0; fp_s3 <= 1'b0;
      ctl_rx_frame <= 1'b0; ctl_rdata <= '0;
    end else begin
      tx_rd_s1 <= tx_rd_g;  tx_rd_s2 <= tx_rd_s1;
      fp_s1 <= rx_tog;  fp_s2 <= fp_s1;  fp_s3 <= fp_s2;
      ctl_rx_frame <= fp_s2 ^ fp_s3;
      if (fp_s2 ^ fp_s3) rx_end <= g2b(rx_fp_g);
      if (rx_rd != rx_rd_tgt) rx_rd <= rx_rd + 1'b1;
      if (tx_wr != tx_wr_tgt) tx_wr <= tx_wr + 1'b1;
      rx_rd_g <= b2g(rx_rd);
      tx_wr_g <= b2g(tx_wr);
      if (ctl_win_wr && ctl_addr[1:0] == 2'd1) rx_rd_tgt <= ctl_wdata[PW-1:0];
      if (ctl_win_wr && ctl_addr[1:0] == 2'd2) tx_wr_tgt <= ctl_wdata[PW-1:0];
      case (ctl_sel)
        SEL_WIN: ctl_rdata <= win_q;
        SEL_RX:  ctl_rdata <= {{(CW-8){1'b0}}, rx_mem[ctl_addr]};
        SEL_TX:  ctl_rdata <= {{(CW-8){1'b0}}, tx_mem[ctl_addr]};
        default: ctl_rdata <= '0;
      endcase
    end
  end

  a_r4_rx_bound: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    (rx_wp - rx_rd_b) <= FULL_LVL);

  a_r4_full_hold: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    (rx_push && rx_full) |=> $stable(rx_wp) && $stable(rx_tog));

  a_r6_tx_bound: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    (tx_wr_b - tx_rd) <= FULL_LVL);

  a_r7_no_underrun: assert property (@(posedge net_clk) disable iff (!net_rst_n)
    (tx_pop && !tx_avail) |=> $stable(tx_rd));

  a_r10_rx_gray_step: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    $countones(rx_rd_g ^ $past(rx_rd_g)) <= 1);

  a_r10_tx_gray_step: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    $countones(tx_wr_g ^ $past(tx_wr_g)) <= 1);

  a_r3_single_pulse: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    ctl_rx_frame |=> !ctl_rx_frame);

  a_r3_end_moves: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    !ctl_rx_frame |-> $stable(rx_end));
endmodule

// File: tb/tb_xdomain_pkt_buf.sv
module tb_xdomain_pkt_buf;
  localparam int AW = 4, CW = 16, DEPTH = 16, PW = 5;
  localparam logic [1:0] S_WIN = 2'd1, S_RX = 2'd2, S_TX = 2'd3;

  logic ctl_clk = 0, net_clk = 0;
  always #5 ctl_clk = ~ctl_clk;
  always #7 net_clk = ~net_clk;

  logic net_rst_n, ctl_rst_n, rx_push, rx_last, rx_full, tx_pop, tx_avail, ctl_we, ctl_rx_frame;
  logic [7:0] rx_byte, tx_byte;
  logic [1:0] ctl_sel;
  logic [AW-1:0] ctl_addr;
  logic [CW-1:0] ctl_wdata, ctl_rdata;

  xdomain_pkt_buf #(.AW(AW), .CW(CW)) dut (
    .net_clk(net_clk), .net_rst_n(net_rst_n), .rx_push(rx_push), .rx_byte(rx_byte),
    .rx_last(rx_last), .rx_full(rx_full), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .tx_avail(tx_avail), .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .ctl_sel(ctl_sel),
    .ctl_addr(ctl_addr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .ctl_rx_frame(ctl_rx_frame));

  int n_chk = 0, n_fail = 0, frames = 0;
  bit finished = 0;

  always @(negedge ctl_clk) if (ctl_rst_n && ctl_rx_frame) frames++;

  function automatic logic [CW-1:0] stat_val(input int lvl);
    return (lvl == 0) ? 16'h8000 : CW'(lvl);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic c_wr(input logic [1:0] s, input int a, input int d);
    @(negedge ctl_clk);
    ctl_sel = s; ctl_addr = a[AW-1:0]; ctl_we = 1; ctl_wdata = d[CW-1:0];
    @(negedge ctl_clk);
    ctl_sel = 0; ctl_we = 0;
  endtask

  task automatic c_rd(input logic [1:0] s, input int a, output int d);
    @(negedge ctl_clk);
    ctl_sel = s; ctl_addr = a[AW-1:0]; ctl_we = 0;
    @(negedge ctl_clk);
    d = int'(ctl_rdata);
    ctl_sel = 0;
  endtask

  task automatic cwait(input int n);
    repeat (n) @(negedge ctl_clk);
  endtask

  task automatic push(input logic [7:0] b, input bit last);
    @(negedge net_clk);
    rx_push = 1; rx_byte = b; rx_last = last;
    @(negedge net_clk);
    rx_push = 0; rx_last = 0;
  endtask

  task automatic wait_frame(input int prev, input string req);
    for (int t = 0; t < 60 && frames <= prev; t++) @(negedge ctl_clk);
    chk(frames > prev, req, frames, prev + 1);
  endtask

  task automatic pop_exp(input logic [7:0] e, input string req);
    @(negedge net_clk);
    for (int t = 0; t < 60 && !tx_avail; t++) @(negedge net_clk);
    chk(tx_avail, req, tx_avail, 1);
    chk(tx_byte == e, req, tx_byte, e);
    tx_pop = 1;
    @(negedge net_clk);
    tx_pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge ctl_clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] rxp, txp, start;
    logic [7:0] bufr [DEPTH];
    int d, prev, len, total, saved;
    void'($urandom(32'h5EED_1234));
    rxp = '0; txp = '0; total = 0;
    net_rst_n = 0; ctl_rst_n = 0;
    rx_push = 0; rx_byte = 0; rx_last = 0; tx_pop = 0;
    ctl_sel = 0; ctl_addr = 0; ctl_we = 0; ctl_wdata = 0;
    cwait(4);
    net_rst_n = 1; ctl_rst_n = 1;
    cwait(2);

    // R1 reset state
    chk(rx_full == 0, "R1 rx_full", rx_full, 0);
    chk(tx_avail == 0, "R1 tx_avail", tx_avail, 0);
    c_rd(S_WIN, 0, d); chk(d == 0, "R1 frame end", d, 0);
    c_rd(S_WIN, 3, d); chk(d == 16'h8000, "R1 status", d, 16'h8000);

    // random frames both ways, wrapping the pointers (R2 R3 R6 R8 R9)
    for (int it = 0; it < 8; it++) begin
      len = 3 + int'($urandom % 6);
      start = rxp;
      prev = frames;
      for (int i = 0; i < len; i++) begin
        bufr[i] = 8'($urandom);
        push(bufr[i], i == len - 1);
        rxp = rxp + 1'b1;
      end
      wait_frame(prev, "R3 pulse");
      c_rd(S_WIN, 0, d); chk(d == int'(rxp), "R3 frame end", d, int'(rxp));
      for (int i = 0; i < len; i++) begin
        c_rd(S_RX, (int'(start) + i) % DEPTH, d);
        chk(d == int'(bufr[i]), "R2/R9 rx byte", d, int'(bufr[i]));
      end
      c_wr(S_WIN, 1, int'(rxp));
      total += len;

      len = 1 + int'($urandom % 8);
      for (int i = 0; i < len; i++) begin
        bufr[i] = 8'($urandom);
        c_wr(S_TX, (int'(txp) + i) % DEPTH, int'(bufr[i]));
      end
      txp = txp + PW'(len);
      c_wr(S_WIN, 2, int'(txp));
      for (int i = 0; i < len; i++) pop_exp(bufr[i], "R6 tx byte");
      cwait(10);
      c_rd(S_WIN, 3, d); chk(d == 16'h8000, "R8 drained", d, 16'h8000);
    end
    chk(total > 2 * DEPTH, "R9 wrapped", total, 2 * DEPTH + 1);
    c_rd(S_WIN, 0, d); chk(d == int'(rxp), "R9 frame end mod", d, int'(rxp));

    // R10 gradual commit, R8 level tracking
    for (int i = 0; i < 5; i++) begin
      bufr[i] = 8'(8'h40 + i);
      c_wr(S_TX, (int'(txp) + i) % DEPTH, int'(bufr[i]));
    end
    c_wr(S_WIN, 2, int'(txp + 5'd5));
    c_rd(S_WIN, 3, d); chk(d < 5, "R10 gradual level", d, 4);
    c_rd(S_WIN, 2, d); chk(d == int'(txp + 5'd5), "R10 target readback", d, int'(txp + 5'd5));
    cwait(10);
    c_rd(S_WIN, 3, d); chk(d == int'(stat_val(5)), "R8 level 5", d, int'(stat_val(5)));
    pop_exp(bufr[0], "R6 pop"); pop_exp(bufr[1], "R6 pop");
    cwait(10);
    c_rd(S_WIN, 3, d); chk(d == int'(stat_val(3)), "R8 level 3", d, int'(stat_val(3)));
    for (int i = 2; i < 5; i++) pop_exp(bufr[i], "R6 pop");
    txp = txp + 5'd5;

    // R7 stray pops
    cwait(10);
    chk(tx_avail == 0, "R7 empty before", tx_avail, 0);
    @(negedge net_clk); tx_pop = 1;
    repeat (3) @(negedge net_clk);
    tx_pop = 0;
    chk(tx_avail == 0, "R7 still empty", tx_avail, 0);
    c_wr(S_TX, int'(txp) % DEPTH, 8'hA5);
    c_wr(S_TX, (int'(txp) + 1) % DEPTH, 8'h3C);
    txp = txp + 5'd2;
    c_wr(S_WIN, 2, int'(txp));
    pop_exp(8'hA5, "R7 first byte");
    pop_exp(8'h3C, "R7 second byte");
    cwait(10);
    c_rd(S_WIN, 3, d); chk(d == 16'h8000, "R7 drained", d, 16'h8000);

    // R11 read-only targets
    c_rd(S_WIN, 0, saved);
    c_wr(S_WIN, 0, 16'h1234);
    c_wr(S_WIN, 3, 16'h0707);
    c_rd(S_WIN, 0, d); chk(d == saved, "R11 frame end kept", d, saved);
    c_rd(S_WIN, 3, d); chk(d == 16'h8000, "R11 status kept", d, 16'h8000);
    c_rd(S_RX, 2, saved);
    c_wr(S_RX, 2, (~saved) & 8'hFF);
    c_rd(S_RX, 2, d); chk(d == saved, "R11 rx ram kept", d, saved);

    // R4 full buffer
    start = rxp;
    prev = frames;
    for (int i = 0; i < DEPTH; i++) begin
      bufr[i] = 8'($urandom);
      push(bufr[i], i == DEPTH - 1);
      rxp = rxp + 1'b1;
    end
    wait_frame(prev, "R4 full frame pulse");
    @(negedge net_clk);
    chk(rx_full == 1, "R4 full", rx_full, 1);
    c_rd(S_WIN, 0, d); chk(d == int'(rxp), "R4 frame end", d, int'(rxp));
    prev = frames;
    push(8'hEE, 1);
    cwait(20);
    chk(frames == prev, "R4 no pulse", frames, prev);
    c_rd(S_WIN, 0, d); chk(d == int'(rxp), "R4 end unchanged", d, int'(rxp));
    c_rd(S_RX, int'(start) % DEPTH, d);
    chk(d == int'(bufr[0]), "R4 oldest byte kept", d, int'(bufr[0]));

    // R5 release
    c_wr(S_WIN, 1, int'(rxp));
    cwait(30);
    @(negedge net_clk);
    chk(rx_full == 0, "R5 full cleared", rx_full, 0);
    start = rxp;
    prev = frames;
    push(8'h11, 0); push(8'h22, 1);
    rxp = rxp + 5'd2;
    wait_frame(prev, "R5 next pulse");
    c_rd(S_WIN, 0, d); chk(d == int'(rxp), "R5 next end", d, int'(rxp));
    c_rd(S_RX, (int'(start) + 1) % DEPTH, d); chk(d == 8'h22, "R5 next data", d, 8'h22);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule